// File: doc/BRIEF.md
# Extended Accumulator Register Bank

This block holds the accumulator and auxiliary registers of an 8-bit processor core that also works on 16-bit and 32-bit quantities. Four byte accumulators (A, B, E, F) can be reached one byte at a time or through overlapping wide names. A with B forms the 16-bit D, E with F forms the 16-bit W, and D with W forms the 32-bit Q. The block also holds three further registers. The 16-bit value register V keeps its contents through reset. A zero register always reads as zero. An 8-bit mode register stores only a small set of defined bits.

The core's decode stage talks to the bank through a set of write ports and a set of registered read ports. Each port carries a register code and an access width. Write data is taken from the low bits of the port's data word. Read data comes back right-aligned and zero-extended one clock after the request. When several write ports cover the same byte in one cycle, a fixed width-based priority decides which write lands.

Top module: `acc_regbank`

## Requirements
- R1: Register codes are 0=A, 1=B, 2=E, 3=F, 4=D, 5=W, 6=Q, 7=V, 8=zero register, 9=mode register, and width codes are 0=8-bit, 1=16-bit, 2=32-bit, 3=reserved. Each code accepts only its own width: 8-bit for A, B, E, F and mode; 16-bit for D, W and V; 32-bit for Q; 8-bit or 16-bit for the zero register.
- R2: The wide names overlap the byte registers. D = {A,B}, W = {E,F} and Q = {A,B,E,F}, with the first-named byte most significant. Reads are right-aligned in rd_data with zero upper bits, and writes use the low bits of wr_data.
- R3: A write through a wide name updates every byte it covers in the same clock edge. A narrow read issued in the following cycle returns the new byte. Bytes that no write covers keep their value.
- R4: Reads are registered. A request sampled at a clock edge appears on rd_data right after that edge. A read and a write of the same register at the same edge return the value from before the write.
- R5: V is not affected by reset. A value written before reset reads back unchanged after it.
- R6: The zero register reads as zero at 8-bit and 16-bit width. A write to it changes no register.
- R7: The mode register stores only the bits set in MODE_MASK (default 8'hC3: bits 7, 6, 1 and 0). All other mode bits read as zero, and writes to them are ignored.
- R8: Reset clears A, B, E, F, the defined mode bits and every rd_data output.
- R9: When write ports overlap on a byte in one cycle, the write with the larger width code wins that byte. On equal width, the lower-numbered port wins. This rule also applies to V and the mode register.
- R10: An access with an undefined register code, or with a width the code does not accept, is treated as illegal. An illegal write changes nothing, and an illegal read returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | NUM_WR | Write enable per write port |
| wr_code | input | NUM_WR x 4 | Register code per write port |
| wr_width | input | NUM_WR x 2 | Access width code per write port |
| wr_data | input | NUM_WR x 32 | Write data per port, low-aligned |
| rd_code | input | NUM_RD x 4 | Register code per read port |
| rd_width | input | NUM_RD x 2 | Access width code per read port |
| rd_data | output | NUM_RD x 32 | Registered, zero-extended read data per port |

## Verification
The bench builds the bank with its default parameters: two write ports, two read ports and mode mask 8'hC3. Two write ports are the smallest setup in which overlapping writes at different widths, and equal-width ties, can be driven in a single cycle. Two read ports allow a narrow name and its wide alias to be observed side by side in the same cycle. With the default mask, set and clear patterns written to the mode register show both stored bits and discarded bits.

// File: rtl/acc_regbank_pkg.sv
package acc_regbank_pkg;

   localparam int LANES  = 4;
   localparam int DATA_W = 8 * LANES;
   localparam int V_W    = 16;
   localparam int MD_W   = 8;
   localparam int CODE_W = 4;
   localparam int WID_W  = 2;

   typedef enum logic [CODE_W-1:0] {
      RC_A    = 4'h0,
      RC_B    = 4'h1,
      RC_E    = 4'h2,
      RC_F    = 4'h3,
      RC_D    = 4'h4,
      RC_W    = 4'h5,
      RC_Q    = 4'h6,
      RC_V    = 4'h7,
      RC_ZERO = 4'h8,
      RC_MODE = 4'h9
   } reg_code_e;

   typedef enum logic [WID_W-1:0] {
      AW_8  = 2'd0,
      AW_16 = 2'd1,
      AW_32 = 2'd2
   } acc_width_e;

   typedef struct packed {
      logic [LANES-1:0] lane_en;
      logic [1:0]       base;
      logic [WID_W-1:0] rank;
      logic             v_we;
      logic             md_we;
   } acc_sel_t;

   function automatic logic acc_legal(input logic [CODE_W-1:0] code,
                                      input logic [WID_W-1:0]  width);
      logic ok;
      case (reg_code_e'(code))
         RC_A, RC_B, RC_E, RC_F, RC_MODE: ok = (width == AW_8);
         RC_D, RC_W, RC_V:                ok = (width == AW_16);
         RC_Q:                            ok = (width == AW_32);
         RC_ZERO:                         ok = (width == AW_8) || (width == AW_16);
         default:                         ok = 1'b0;
      endcase
      return ok;
   endfunction

   function automatic acc_sel_t acc_decode(input logic                en,
                                           input logic [CODE_W-1:0] code,
                                           input logic [WID_W-1:0]  width);
      acc_sel_t s;
      s = '0;
      s.rank = width;
      if (en && acc_legal(code, width)) begin
         case (reg_code_e'(code))
            RC_A:    begin s.lane_en = 4'b1000; s.base = 2'd3; end
            RC_B:    begin s.lane_en = 4'b0100; s.base = 2'd2; end
            RC_E:    begin s.lane_en = 4'b0010; s.base = 2'd1; end
            RC_F:    begin s.lane_en = 4'b0001; s.base = 2'd0; end
            RC_D:    begin s.lane_en = 4'b1100; s.base = 2'd2; end
            RC_W:    begin s.lane_en = 4'b0011; s.base = 2'd0; end
            RC_Q:    begin s.lane_en = 4'b1111; s.base = 2'd0; end
            RC_V:    s.v_we  = 1'b1;
            RC_MODE: s.md_we = 1'b1;
            default: s.lane_en = '0;
         endcase
      end
      return s;
   endfunction

endpackage

// File: rtl/acc_wr_decode.sv
module acc_wr_decode
   import acc_regbank_pkg::*;
(
   input  logic              en,
   input  logic [CODE_W-1:0] code,
   input  logic [WID_W-1:0]  width,
   output acc_sel_t          sel
);

   always_comb begin
      sel = acc_decode(en, code, width);
   end

endmodule

// File: rtl/acc_byte_lane.sv
module acc_byte_lane
   import acc_regbank_pkg::*;
#(
   parameter int NUM_WR = 2,
   parameter int LANE   = 0
)(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_WR-1:0]              hit,
   input  logic [NUM_WR-1:0][WID_W-1:0]   rank,
   input  logic [NUM_WR-1:0][1:0]         base,
   input  logic [NUM_WR-1:0][DATA_W-1:0]  wdata,
   output logic [7:0]                     q
);

   localparam logic [1:0] LIDX = 2'(LANE);

   logic             we;
   logic [7:0]       nxt;
   logic [WID_W-1:0] best_rank;

   always_comb begin
      we        = 1'b0;
      nxt       = q;
      best_rank = '0;
      for (int p = 0; p < NUM_WR; p++) begin
         if (hit[p] && (!we || (rank[p] > best_rank))) begin
            we        = 1'b1;
            best_rank = rank[p];
            nxt       = wdata[p][{LIDX - base[p], 3'b000} +: 8];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= nxt;
   end

   AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q)); // R3

   generate
      if (NUM_WR >= 2) begin : g_pair_chk
         logic [7:0] byte0, byte1;
         assign byte0 = wdata[0][{LIDX - base[0], 3'b000} +: 8];
         assign byte1 = wdata[1][{LIDX - base[1], 3'b000} +: 8];

         AST_WIDE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[0] && hit[1] && (rank[1] > rank[0])) |=> (q == $past(byte1))); // R9
         AST_TIE_LOW_PORT: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[0] && hit[1] && (rank[1] <= rank[0])) |=> (q == $past(byte0))); // R9
      end
   endgenerate

endmodule

// File: rtl/acc_read_port.sv
module acc_read_port
   import acc_regbank_pkg::*;
#(
   parameter logic [MD_W-1:0] MODE_MASK = 8'hC3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code,
   input  logic [WID_W-1:0]  width,
   input  logic [DATA_W-1:0] acc_q,
   input  logic [V_W-1:0]    v_q,
   input  logic [MD_W-1:0]   md_q,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] val;

   always_comb begin
      val = '0;
      if (acc_legal(code, width)) begin
         case (reg_code_e'(code))
            RC_A:    val = {{(DATA_W-8){1'b0}},    acc_q[31:24]};
            RC_B:    val = {{(DATA_W-8){1'b0}},    acc_q[23:16]};
            RC_E:    val = {{(DATA_W-8){1'b0}},    acc_q[15:8]};
            RC_F:    val = {{(DATA_W-8){1'b0}},    acc_q[7:0]};
            RC_D:    val = {{(DATA_W-16){1'b0}},   acc_q[31:16]};
            RC_W:    val = {{(DATA_W-16){1'b0}},   acc_q[15:0]};
            RC_Q:    val = acc_q;
            RC_V:    val = {{(DATA_W-V_W){1'b0}},  v_q};
            RC_MODE: val = {{(DATA_W-MD_W){1'b0}}, md_q & MODE_MASK};
            default: val = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= val;
   end

   AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (code == RC_ZERO) |=> (rd_data == '0)); // R6
   AST_BAD_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_legal(code, width) |=> (rd_data == '0)); // R10
   AST_MODE_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
      (code == RC_MODE) |=> ((rd_data & ~{{(DATA_W-MD_W){1'b0}}, MODE_MASK}) == '0)); // R7

endmodule

// File: rtl/acc_regbank.sv
module acc_regbank
   import acc_regbank_pkg::*;
#(
   parameter int              NUM_WR    = 2,
   parameter int              NUM_RD    = 2,
   parameter logic [MD_W-1:0] MODE_MASK = 8'hC3,
   parameter int              MODE_BITS = 4
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_WR-1:0]             wr_en,
   input  logic [NUM_WR-1:0][CODE_W-1:0] wr_code,
   input  logic [NUM_WR-1:0][WID_W-1:0]  wr_width,
   input  logic [NUM_WR-1:0][DATA_W-1:0] wr_data,
   input  logic [NUM_RD-1:0][CODE_W-1:0] rd_code,
   input  logic [NUM_RD-1:0][WID_W-1:0]  rd_width,
   output logic [NUM_RD-1:0][DATA_W-1:0] rd_data
);

   function automatic int count_bits(input logic [MD_W-1:0] m);
      int n;
      n = 0;
      for (int i = 0; i < MD_W; i++) n += int'(m[i]);
      return n;
   endfunction

   localparam int MASK_BITS = count_bits(MODE_MASK);

   generate
      if (NUM_WR < 1) begin : g_bad_wr
         $error("acc_regbank: NUM_WR must be at least 1");
      end
      if (NUM_RD < 1) begin : g_bad_rd
         $error("acc_regbank: NUM_RD must be at least 1");
      end
      if (MASK_BITS != MODE_BITS) begin : g_bad_mask
         $error("acc_regbank: MODE_MASK must set exactly MODE_BITS bits");
      end
   endgenerate

   acc_sel_t                      sel [NUM_WR];
   logic [NUM_WR-1:0][WID_W-1:0]  port_rank;
   logic [NUM_WR-1:0][1:0]        port_base;
   logic [LANES-1:0][NUM_WR-1:0]  lane_hit;
   logic [DATA_W-1:0]             acc_q;
   logic [V_W-1:0]                v_q, v_nxt;
   logic [MD_W-1:0]               md_q, md_nxt;
   logic                          v_we, md_we;

   for (genvar p = 0; p < NUM_WR; p++) begin : g_wr
      acc_wr_decode u_dec (
         .en    (wr_en[p]),
         .code  (wr_code[p]),
         .width (wr_width[p]),
         .sel   (sel[p])
      );
      assign port_rank[p] = sel[p].rank;
      assign port_base[p] = sel[p].base;
      for (genvar l = 0; l < LANES; l++) begin : g_hit
         assign lane_hit[l][p] = sel[p].lane_en[l];
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      acc_byte_lane #(.NUM_WR(NUM_WR), .LANE(l)) u_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .hit   (lane_hit[l]),
         .rank  (port_rank),
         .base  (port_base),
         .wdata (wr_data),
         .q     (acc_q[8*l +: 8])
      );
   end

   // Lowest-numbered port is applied last, so it wins equal-width ties.
   always_comb begin
      v_we   = 1'b0;
      md_we  = 1'b0;
      v_nxt  = v_q;
      md_nxt = md_q;
      for (int p = NUM_WR-1; p >= 0; p--) begin
         if (sel[p].v_we) begin
            v_we  = 1'b1;
            v_nxt = wr_data[p][V_W-1:0];
         end
         if (sel[p].md_we) begin
            md_we  = 1'b1;
            md_nxt = wr_data[p][MD_W-1:0];
         end
      end
   end

   // Value register: deliberately outside the reset domain.
   always_ff @(posedge clk) begin
      if (v_we) v_q <= v_nxt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     md_q <= '0;
      else if (md_we) md_q <= md_nxt & MODE_MASK;
   end

   for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
      acc_read_port #(.MODE_MASK(MODE_MASK)) u_rd (
         .clk     (clk),
         .rst_n   (rst_n),
         .code    (rd_code[r]),
         .width   (rd_width[r]),
         .acc_q   (acc_q),
         .v_q     (v_q),
         .md_q    (md_q),
         .rd_data (rd_data[r])
      );
   end

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> ((acc_q == '0) && (md_q == '0))); // R8

endmodule

// File: tb/acc_regbank_tb_top.sv
module acc_regbank_tb_top;

   localparam int NW = 2;
   localparam int NR = 2;
   localparam logic [7:0] MASK = 8'hC3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [NW-1:0]        wr_en;
   logic [NW-1:0][3:0]   wr_code;
   logic [NW-1:0][1:0]   wr_width;
   logic [NW-1:0][31:0]  wr_data;
   logic [NR-1:0][3:0]   rd_code;
   logic [NR-1:0][1:0]   rd_width;
   logic [NR-1:0][31:0]  rd_data;

   acc_regbank #(.NUM_WR(NW), .NUM_RD(NR), .MODE_MASK(MASK), .MODE_BITS(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(wr_code),
      .wr_width(wr_width), .wr_data(wr_data), .rd_code(rd_code),
      .rd_width(rd_width), .rd_data(rd_data)
   );

   // Reference state: bytes A,B,E,F kept in one word, A most significant.
   logic [31:0] m_q  = '0;
   logic [15:0] m_v  = '0;
   bit          m_v_ok = 1'b0;
   logic [7:0]  m_md = '0;
   int checks = 0;
   int errors = 0;
   string req = "R8";

   function automatic bit m_legal(int c, int w);
      if (c <= 3 || c == 9) return w == 0;
      if (c == 4 || c == 5 || c == 7) return w == 1;
      if (c == 6) return w == 2;
      if (c == 8) return (w == 0) || (w == 1);
      return 1'b0;
   endfunction

   function automatic logic [31:0] m_read(int c, int w);
      if (!m_legal(c, w)) return 32'h0;
      case (c)
         0: return {24'h0, m_q[31:24]};
         1: return {24'h0, m_q[23:16]};
         2: return {24'h0, m_q[15:8]};
         3: return {24'h0, m_q[7:0]};
         4: return {16'h0, m_q[31:16]};
         5: return {16'h0, m_q[15:0]};
         6: return m_q;
         7: return {16'h0, m_v};
         9: return {24'h0, m_md};
         default: return 32'h0;
      endcase
   endfunction

   task automatic m_write(int c, logic [31:0] d);
      case (c)
         0: m_q[31:24] = d[7:0];
         1: m_q[23:16] = d[7:0];
         2: m_q[15:8]  = d[7:0];
         3: m_q[7:0]   = d[7:0];
         4: m_q[31:16] = d[15:0];
         5: m_q[15:0]  = d[15:0];
         6: m_q        = d;
         7: begin m_v = d[15:0]; m_v_ok = 1'b1; end
         9: m_md = d[7:0] & MASK;
         default: ;
      endcase
   endtask

   task automatic step();
      logic [31:0] exp_v [NR];
      bit          ok [NR];
      for (int r = 0; r < NR; r++) begin
         ok[r] = 1'b1;
         if (!rst_n) exp_v[r] = 32'h0;
         else begin
            exp_v[r] = m_read(int'(rd_code[r]), int'(rd_width[r]));
            if (rd_code[r] == 4'd7 && m_legal(7, int'(rd_width[r])) && !m_v_ok) ok[r] = 1'b0;
         end
      end
      if (!rst_n) begin
         m_q  = '0;
         m_md = '0;
      end else begin
         // Narrow widths first, higher port first: later writes overwrite.
         for (int rk = 0; rk < 3; rk++)
            for (int p = NW-1; p >= 0; p--)
               if (wr_en[p] && m_legal(int'(wr_code[p]), int'(wr_width[p])) &&
                   int'(wr_width[p]) == rk)
                  m_write(int'(wr_code[p]), wr_data[p]);
      end
      @(posedge clk);
      #1;
      for (int r = 0; r < NR; r++) begin
         if (ok[r]) begin
            checks++;
            if (rd_data[r] !== exp_v[r]) begin
               errors++;
               $display("FAIL %s port%0d code %0d width %0d: got %h expected %h",
                        req, r, rd_code[r], rd_width[r], rd_data[r], exp_v[r]);
            end
         end
      end
   endtask

   task automatic wr(int p, int c, int w, logic [31:0] d);
      wr_en[p]    = 1'b1;
      wr_code[p]  = 4'(c);
      wr_width[p] = 2'(w);
      wr_data[p]  = d;
   endtask

   task automatic rd(int r, int c, int w);
      rd_code[r]  = 4'(c);
      rd_width[r] = 2'(w);
   endtask

   task automatic idle();
      wr_en = '0;
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      wr_en = '0; wr_code = '0; wr_width = '0; wr_data = '0;
      rd_code = '0; rd_width = '0;
      rd(0, 8, 0); rd(1, 8, 1);
      // R8: reset state
      req = "R8";
      step(); step(); step();
      rst_n = 1'b1;
      rd(0, 6, 2); rd(1, 4, 1);
      step();

      // R1 / R2: byte writes seen through wide aliases
      req = "R2";
      wr(0, 0, 0, 32'hFFFF_FF12); wr(1, 1, 0, 32'h0000_0034);
      step(); idle();
      rd(0, 4, 1); rd(1, 6, 2); step();
      req = "R1";
      wr(0, 2, 0, 32'h56); wr(1, 3, 0, 32'h78);
      step(); idle();
      rd(0, 5, 1); rd(1, 6, 2); step();
      rd(0, 0, 0); rd(1, 3, 0); step();

      // R3: wide write, narrow reads next cycle
      req = "R3";
      wr(0, 6, 2, 32'hDEAD_BEEF); rd(0, 0, 0); rd(1, 2, 0);
      step(); idle();
      step();
      rd(0, 1, 0); rd(1, 3, 0); step();
      wr(1, 5, 1, 32'h0000_1357); step(); idle();
      rd(0, 4, 1); rd(1, 5, 1); step();

      // R4: same-edge read returns old value, next read returns new
      req = "R4";
      rd(0, 2, 0); rd(1, 6, 2);
      wr(0, 2, 0, 32'h55); step(); idle();
      step();

      // R6: zero register
      req = "R6";
      rd(0, 8, 0); rd(1, 8, 1);
      wr(0, 8, 0, 32'hFFFF_FFFF); wr(1, 8, 1, 32'hFFFF_FFFF);
      step(); idle(); step();
      rd(0, 6, 2); rd(1, 9, 0); step();

      // R7: mode register mask
      req = "R7";
      wr(0, 9, 0, 32'hFF); rd(0, 9, 0); step(); idle(); step();
      wr(1, 9, 0, 32'h3C); step(); idle(); step();
      wr(0, 9, 0, 32'h81); step(); idle(); step();

      // R10: illegal widths and codes
      req = "R10";
      rd(0, 0, 0); rd(1, 6, 2);
      wr(0, 0, 1, 32'h99); wr(1, 15, 0, 32'hFFFF_FFFF); step(); idle(); step();
      wr(0, 6, 3, 32'h0); wr(1, 4, 2, 32'h0); step(); idle(); step();
      rd(0, 4, 0); rd(1, 12, 1); step();
      rd(0, 7, 2); rd(1, 6, 1); step();

      // R9: overlapping writes
      req = "R9";
      rd(0, 6, 2); rd(1, 7, 1);
      wr(0, 0, 0, 32'h11); wr(1, 4, 1, 32'h2233); step(); idle(); step();
      wr(0, 6, 2, 32'hA1B2_C3D4); wr(1, 5, 1, 32'h9999); step(); idle(); step();
      wr(0, 2, 0, 32'h44); wr(1, 2, 0, 32'h77); step(); idle(); step();
      wr(0, 7, 1, 32'h1111); wr(1, 7, 1, 32'h2222); step(); idle(); step();
      wr(0, 3, 0, 32'hEE); wr(1, 6, 2, 32'h0102_0304); step(); idle(); step();
      rd(0, 9, 0);
      wr(0, 9, 0, 32'h02); wr(1, 9, 0, 32'h01); step(); idle(); step();

      // R5: value register survives reset; R8 clears the rest
      req = "R5";
      wr(0, 7, 1, 32'hA5C3); wr(1, 6, 2, 32'hCAFE_F00D); step(); idle();
      wr(0, 9, 0, 32'hC3); step(); idle();
      rst_n = 1'b0; rd(0, 7, 1); rd(1, 6, 2); step(); step();
      rst_n = 1'b1; step();
      req = "R8";
      rd(0, 9, 0); rd(1, 6, 2); step();
      req = "R5";
      rd(0, 7, 1); rd(1, 4, 1); step();

      // R2: mixed traffic
      req = "R2";
      for (int i = 0; i < 300; i++) begin
         idle();
         for (int p = 0; p < NW; p++)
            if ($urandom_range(0, 2) != 0)
               wr(p, $urandom_range(0, 10), $urandom_range(0, 3), $urandom());
         for (int r = 0; r < NR; r++)
            rd(r, $urandom_range(0, 10), $urandom_range(0, 3));
         step();
      end
      idle();
      step();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule